// File: doc/BRIEF.md
# Parallel Automaton Pattern Matcher

This block scans a stream of 8-bit symbols, one per clock, against a programmable non-deterministic automaton. The automaton is built from N identical state elements, 16 by default. Each element owns a 256-entry, one-bit-wide class table indexed by the incoming byte. An element is active for a symbol when it was enabled and its table holds a 1 at that byte. Any set of byte values can therefore match in a single cycle.

A successor matrix routes every active element to any number of other elements, which are enabled for the next symbol. Many partial paths are tracked side by side. A word from a dictionary of any size is recognised after exactly as many symbols as it has letters.

Elements flagged as start elements are enabled on every symbol, so a match may begin anywhere in the stream. Elements flagged as report elements raise a one-cycle match pulse carrying their index. Software programs the class tables, the successor matrix and both flag sets through a single-bit write port while scanning is off. It then raises the scan enable and streams symbols in.

Top module: `nfa_scan_top`

## Requirements
- R1: After a synchronous reset, match_valid and match_id are 0, no element is active, and the start flags, report flags and successor matrix are all cleared.
- R2: An enabled element becomes active on byte b exactly when bit b of its class table is 1. With several bits set (for example space, comma, period and carriage return 0x0D), any of those bytes matches in one cycle.
- R3: A start element is enabled for every symbol, so a pattern beginning at any stream position is found.
- R4: An active element enables every element whose successor bit it holds for the next accepted symbol, so several successors are tracked at once.
- R5: An enabled element whose class bit is 0 for the current byte is not active, and its successors are not enabled by it: the path ends.
- R6: A symbol is accepted at a clock edge where sym_valid and scan_en are both 1. If a report element becomes active on it, match_valid is 1 for exactly one cycle, visible after the second rising edge counted from the accepting edge.
- R7: If several report elements become active on the same symbol, match_id is the lowest such element index.
- R8: Edges with sym_valid at 0 leave the active set unchanged and produce no match, so a word split by idle cycles is still found.
- R9: A configuration write takes effect only when cfg_we is 1 and scan_en is 0. cfg_kind selects the target: 0 writes class bit cfg_addr of element cfg_elem; 1 writes the successor bit from element cfg_elem to element cfg_addr[IDX_W-1:0]; 2 writes the start flag of cfg_elem; 3 writes its report flag. cfg_data is the value written.
- R10: While scan_en is 0, symbols are ignored and the active set is cleared, so every scan starts with only start elements enabled.
- R11: A word of L letters is reported in response to its L-th letter, independently of how many other words are programmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_en | input | 1 | 1 = scanning, 0 = configuration allowed and active set cleared |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 2 | Write target: 0 class bit, 1 successor bit, 2 start flag, 3 report flag |
| cfg_elem | input | IDX_W | Element being configured |
| cfg_addr | input | SYM_W | Byte value (class write) or destination element (successor write) |
| cfg_data | input | 1 | Bit value written |
| sym_valid | input | 1 | Symbol present on sym |
| sym | input | SYM_W | Incoming symbol |
| match_valid | output | 1 | One-cycle report pulse |
| match_id | output | IDX_W | Index of the reporting element (lowest wins) |

## Verification
Class tables are read synchronously, so the active set and the match pulse for a symbol are due after the second rising edge counted from the edge that accepts it. The bench model keeps the same one-symbol delay stage and compares the outputs at each falling edge. Directed word checks feed the letters and then one idle cycle, and only then read match_valid and match_id. The check on the following cycle confirms that the pulse has dropped. Configuration writes update the model only at edges where scan_en is 0. Idle and scan-off cycles run the model too, so hold and clear behaviour is checked at the outputs.

// File: rtl/nfa_pkg.sv
package nfa_pkg;
  typedef enum logic [1:0] {
    CFG_CLASS  = 2'd0,
    CFG_SUCC   = 2'd1,
    CFG_START  = 2'd2,
    CFG_REPORT = 2'd3
  } cfg_kind_e;
endpackage

// File: rtl/nfa_class_mem.sv
// One element's symbol-class table: 2**SYM_W x 1, registered read, block RAM style.
module nfa_class_mem #(
  parameter int SYM_W = 8
) (
  input  logic             clk,
  input  logic             we,
  input  logic [SYM_W-1:0] waddr,
  input  logic             wdata,
  input  logic [SYM_W-1:0] raddr,
  output logic             hit
);
  localparam int DEPTH = 1 << SYM_W;

  logic mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    hit <= mem[raddr];
  end
endmodule

// File: rtl/nfa_route.sv
// Successor matrix and start flags; forms the enable vector for the next symbol.
module nfa_route #(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_succ,
  input  logic             wr_start,
  input  logic [IDX_W-1:0] src,
  input  logic [IDX_W-1:0] dst,
  input  logic             bit_in,
  input  logic [N-1:0]     act,
  output logic [N-1:0]     en,
  output logic [N-1:0]     start_vec
);
  logic [N-1:0] succ_q [N];
  logic [N-1:0] start_q;

  for (genvar i = 0; i < N; i++) begin : g_row
    always_ff @(posedge clk) begin
      if (rst) begin
        succ_q[i]  <= '0;
        start_q[i] <= 1'b0;
      end else begin
        if (wr_succ && src == IDX_W'(i)) succ_q[i][dst] <= bit_in;
        if (wr_start && src == IDX_W'(i)) start_q[i] <= bit_in;
      end
    end
  end

  always_comb begin
    en = start_q;
    for (int i = 0; i < N; i++) begin
      if (act[i]) en = en | succ_q[i];
    end
  end

  assign start_vec = start_q;
endmodule

// File: rtl/nfa_report.sv
// Report flags and registered lowest-index match output.
module nfa_report #(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_rpt,
  input  logic [IDX_W-1:0] elem,
  input  logic             bit_in,
  input  logic             upd,
  input  logic [N-1:0]     act_new,
  output logic [N-1:0]     rpt_vec,
  output logic             match_valid,
  output logic [IDX_W-1:0] match_id
);
  logic [N-1:0]     rpt_q;
  logic [N-1:0]     hits;
  logic [IDX_W-1:0] win;
  logic             any_hit;

  always_ff @(posedge clk) begin
    if (rst) rpt_q <= '0;
    else if (wr_rpt) rpt_q[elem] <= bit_in;
  end

  assign hits    = act_new & rpt_q;
  assign any_hit = |hits;

  always_comb begin
    win = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (hits[k]) win = IDX_W'(k);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      match_valid <= 1'b0;
      match_id    <= '0;
    end else if (upd) begin
      match_valid <= any_hit;
      if (any_hit) match_id <= win;
    end else begin
      match_valid <= 1'b0;
    end
  end

  assign rpt_vec = rpt_q;
endmodule

// File: rtl/nfa_scan_top.sv
module nfa_scan_top
  import nfa_pkg::*;
#(
  parameter int N     = 16,
  parameter int SYM_W = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scan_en,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_kind,
  input  logic [IDX_W-1:0] cfg_elem,
  input  logic [SYM_W-1:0] cfg_addr,
  input  logic             cfg_data,
  input  logic             sym_valid,
  input  logic [SYM_W-1:0] sym,
  output logic             match_valid,
  output logic [IDX_W-1:0] match_id
);
  cfg_kind_e    kind;
  logic         cfg_ok;
  logic [N-1:0] hit_vec;
  logic [N-1:0] en_vec;
  logic [N-1:0] act_q;
  logic [N-1:0] act_next;
  logic [N-1:0] start_q;
  logic [N-1:0] rpt_q;
  logic         hv_q;
  logic         upd;

  assign kind   = cfg_kind_e'(cfg_kind);
  assign cfg_ok = cfg_we & ~scan_en;

  for (genvar i = 0; i < N; i++) begin : g_elem
    nfa_class_mem #(.SYM_W(SYM_W)) u_mem (
      .clk  (clk),
      .we   (cfg_ok && kind == CFG_CLASS && cfg_elem == IDX_W'(i)),
      .waddr(cfg_addr),
      .wdata(cfg_data),
      .raddr(sym),
      .hit  (hit_vec[i])
    );
  end

  nfa_route #(.N(N), .IDX_W(IDX_W)) u_route (
    .clk      (clk),
    .rst      (rst),
    .wr_succ  (cfg_ok && kind == CFG_SUCC),
    .wr_start (cfg_ok && kind == CFG_START),
    .src      (cfg_elem),
    .dst      (cfg_addr[IDX_W-1:0]),
    .bit_in   (cfg_data),
    .act      (act_q),
    .en       (en_vec),
    .start_vec(start_q)
  );

  // Symbol accepted at this edge; its class bits arrive one edge later.
  always_ff @(posedge clk) begin
    if (rst) hv_q <= 1'b0;
    else     hv_q <= scan_en & sym_valid;
  end

  assign act_next = hit_vec & en_vec;
  assign upd      = hv_q & scan_en;

  always_ff @(posedge clk) begin
    if (rst)          act_q <= '0;
    else if (!scan_en) act_q <= '0;
    else if (hv_q)    act_q <= act_next;
  end

  nfa_report #(.N(N), .IDX_W(IDX_W)) u_report (
    .clk        (clk),
    .rst        (rst),
    .wr_rpt     (cfg_ok && kind == CFG_REPORT),
    .elem       (cfg_elem),
    .bit_in     (cfg_data),
    .upd        (upd),
    .act_new    (act_next),
    .rpt_vec    (rpt_q),
    .match_valid(match_valid),
    .match_id   (match_id)
  );
endmodule

// File: rtl/nfa_scan_chk.sv
module nfa_scan_chk #(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             scan_en,
  input logic             sym_valid,
  input logic             match_valid,
  input logic [IDX_W-1:0] match_id,
  input logic [N-1:0]     act_q,
  input logic [N-1:0]     start_q,
  input logic [N-1:0]     rpt_q
);
  a_r6_match_needs_symbol: assert property (@(posedge clk) disable iff (rst)
    !($past(scan_en, 2) && $past(sym_valid, 2)) |-> !match_valid);

  a_r6_reporter_active: assert property (@(posedge clk) disable iff (rst)
    match_valid |-> (act_q[match_id] && rpt_q[match_id]));

  a_r7_lowest_index: assert property (@(posedge clk) disable iff (rst)
    match_valid |-> ((act_q & rpt_q & ((N'(1) << match_id) - N'(1))) == '0));

  a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    ($past(scan_en) && !($past(sym_valid, 2) && $past(scan_en, 2))) |-> $stable(act_q));

  a_r9_flags_frozen_in_scan: assert property (@(posedge clk) disable iff (rst)
    $past(scan_en) |-> ($stable(start_q) && $stable(rpt_q)));

  a_r10_cleared_when_off: assert property (@(posedge clk) disable iff (rst)
    !$past(scan_en) |-> (act_q == '0));
endmodule

bind nfa_scan_top nfa_scan_chk #(.N(N), .IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .scan_en    (scan_en),
  .sym_valid  (sym_valid),
  .match_valid(match_valid),
  .match_id   (match_id),
  .act_q      (act_q),
  .start_q    (start_q),
  .rpt_q      (rpt_q)
);

// File: tb/tb_nfa_scan_top.sv
`timescale 1ns/1ps
module tb_nfa_scan_top;
  localparam int N = 16;
  localparam int IW = 4;

  logic          clk = 0;
  logic          rst, scan_en, cfg_we, cfg_data, sym_valid;
  logic [1:0]    cfg_kind;
  logic [IW-1:0] cfg_elem;
  logic [7:0]    cfg_addr, sym;
  logic          match_valid;
  logic [IW-1:0] match_id;

  int n_vec = 0, n_bad = 0;

  always #10 clk = ~clk;

  nfa_scan_top #(.N(N), .SYM_W(8)) dut (
    .clk(clk), .rst(rst), .scan_en(scan_en), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
    .cfg_elem(cfg_elem), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .sym_valid(sym_valid), .sym(sym), .match_valid(match_valid), .match_id(match_id));

  // Bench model
  bit         m_mask [N][256];
  bit [N-1:0] m_succ [N];
  bit [N-1:0] m_start, m_rpt, m_act;
  bit         m_hv;
  bit [7:0]   m_sym;
  bit         exp_mv;
  int         exp_id;

  function automatic int lowest(bit [N-1:0] v);
    for (int k = 0; k < N; k++) if (v[k]) return k;
    return 0;
  endfunction

  task automatic model_edge();
    bit [N-1:0] en, na;
    if (!scan_en) begin
      m_act = '0; exp_mv = 0;
    end else if (m_hv) begin
      en = m_start;
      for (int i = 0; i < N; i++) if (m_act[i]) en |= m_succ[i];
      for (int j = 0; j < N; j++) na[j] = en[j] & m_mask[j][m_sym];
      m_act = na;
      exp_mv = |(na & m_rpt);
      if (exp_mv) exp_id = lowest(na & m_rpt);
    end else begin
      exp_mv = 0;
    end
    if (cfg_we && !scan_en) begin
      case (cfg_kind)
        2'd0: m_mask[cfg_elem][cfg_addr] = cfg_data;
        2'd1: m_succ[cfg_elem][cfg_addr[IW-1:0]] = cfg_data;
        2'd2: m_start[cfg_elem] = cfg_data;
        default: m_rpt[cfg_elem] = cfg_data;
      endcase
    end
    m_hv  = sym_valid && scan_en;
    m_sym = sym;
  endtask

  task automatic cycle(bit v, bit [7:0] s, bit we, bit [1:0] k, int e, int a, bit d);
    sym_valid = v; sym = s; cfg_we = we; cfg_kind = k;
    cfg_elem = e[IW-1:0]; cfg_addr = a[7:0]; cfg_data = d;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    n_vec++;
    if (match_valid !== exp_mv || (exp_mv && match_id !== exp_id[IW-1:0])) begin
      n_bad++;
      $display("FAIL R6 model: valid=%0b id=%0d expected valid=%0b id=%0d",
               match_valid, match_id, exp_mv, exp_id);
    end
    cfg_we = 0;
  endtask

  task automatic idle(); cycle(0, 8'h00, 0, 0, 0, 0, 0); endtask
  task automatic feed(bit [7:0] s); cycle(1, s, 0, 0, 0, 0, 0); endtask
  task automatic cfg(bit [1:0] k, int e, int a, bit d); cycle(0, 8'h00, 1, k, e, a, d); endtask

  task automatic word(string w);
    for (int i = 0; i < w.len(); i++) feed(w[i]);
  endtask

  task automatic want(bit v, int id, string tag);
    n_vec++;
    if (match_valid !== v || (v && match_id !== id[IW-1:0])) begin
      n_bad++;
      $display("FAIL %s: valid=%0b id=%0d expected valid=%0b id=%0d",
               tag, match_valid, match_id, v, id);
    end
  endtask

  initial begin
    #4_000_000;
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0097));
    rst = 1; scan_en = 0; cfg_we = 0; cfg_kind = 0; cfg_elem = 0; cfg_addr = 0;
    cfg_data = 0; sym_valid = 0; sym = 0;
    m_start = '0; m_rpt = '0; m_act = '0; m_hv = 0; exp_mv = 0; exp_id = 0;
    for (int i = 0; i < N; i++) m_succ[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    want(0, 0, "R1 reset match_valid");
    n_vec++;
    if (match_id !== 0) begin
      n_bad++; $display("FAIL R1 reset match_id=%0d expected 0", match_id);
    end
    rst = 0;

    // Clear every class table (R9 writes with scan off)
    for (int e = 0; e < N; e++)
      for (int a = 0; a < 256; a++) cfg(0, e, a, 0);

    // Dictionary: cat car cart cab; terminators; lone t
    cfg(0, 0, "c", 1); cfg(2, 0, 0, 1);
    cfg(0, 1, "a", 1);
    cfg(0, 2, "t", 1); cfg(3, 2, 0, 1);
    cfg(0, 3, "r", 1); cfg(3, 3, 0, 1);
    cfg(0, 4, "t", 1); cfg(3, 4, 0, 1);
    cfg(0, 5, "b", 1); cfg(3, 5, 0, 1);
    cfg(0, 6, " ", 1); cfg(0, 6, ",", 1); cfg(0, 6, ".", 1); cfg(0, 6, 8'h0d, 1);
    cfg(2, 6, 0, 1); cfg(3, 6, 0, 1);
    cfg(0, 7, "t", 1); cfg(2, 7, 0, 1); cfg(3, 7, 0, 1);
    cfg(1, 0, 1, 1); cfg(1, 1, 2, 1); cfg(1, 1, 3, 1); cfg(1, 1, 5, 1); cfg(1, 3, 4, 1);

    scan_en = 1; idle(); idle();
    word("cat"); idle(); want(1, 2, "R7 cat+t both report, lowest 2");
    idle(); want(0, 0, "R6 pulse lasts one cycle");
    word("car"); idle(); want(1, 3, "R4 car via fan-out");
    feed("t"); idle(); want(1, 4, "R11 cart on 4th letter");
    word("cab"); idle(); want(1, 5, "R4 cab third branch");
    word("xxcat"); idle(); want(1, 2, "R3 match mid-stream");
    word("cxt"); idle(); want(1, 7, "R5 broken path ends");
    feed(","); idle(); want(1, 6, "R2 comma in class");
    feed("."); idle(); want(1, 6, "R2 period in class");
    feed(8'h0d); idle(); want(1, 6, "R2 CR in class");
    feed("q"); idle(); want(0, 0, "R2 byte outside class");
    feed("c"); idle(); idle(); idle(); feed("a"); idle(); idle();
    want(0, 0, "R8 no match in gap");
    feed("t"); idle(); want(1, 2, "R8 word split by idle cycles");

    word("ca"); idle();
    scan_en = 0; idle(); idle(); idle();
    want(0, 0, "R10 no match while off");
    scan_en = 1; idle();
    feed("t"); idle(); want(1, 7, "R10 path cleared by scan off");

    cfg(0, 8, "z", 1); cfg(2, 8, 0, 1); cfg(3, 8, 0, 1);
    feed("z"); idle(); want(0, 0, "R9 write ignored while scanning");
    scan_en = 0; idle();
    cfg(0, 8, "z", 1); cfg(2, 8, 0, 1); cfg(3, 8, 0, 1);
    scan_en = 1; idle();
    feed("z"); idle(); want(1, 8, "R9 write accepted when off");

    // Random stream against the model (R2..R8, R11)
    begin
      string alpha = "catrbxz ,.q";
      for (int n = 0; n < 3000; n++) begin
        if ($urandom_range(0, 3) == 0) idle();
        else feed(alpha[$urandom_range(0, alpha.len() - 1)]);
      end
    end
    idle(); idle();

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule